// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link (chip select, serial clock, data in, data out) for a 256 x 8 device. The system side issues one command at a time with a valid/ready handshake. Each command carries an operation code, an 8-bit address and an 8-bit write value. The controller builds the serial frame, produces the serial clock by dividing the system clock, and runs the frame on the wire. When the command has finished, it returns a one-cycle completion pulse. For a read, that pulse carries the byte that was read. For a timed-out program command, it carries an error bit.

A read drops the leading zero that the device sends before its data, then collects eight data bits, most significant first. Program commands (write, erase, erase-all, write-all) finish by dropping chip select, which starts the device's internal cycle. The controller then holds chip select low for a minimum gap and raises it again. It polls the data-out line until the device reports ready, or until a poll limit runs out. Every command ends with the same enforced chip-select-low gap before the next command can be accepted.

Back-pressure applies only on the command side. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until the closing gap has elapsed. The response side cannot be stalled: `rsp_valid` is a single-cycle pulse, and the caller must take `rsp_data` and `rsp_err` in that cycle.

Top module: `uwire_host`

## Requirements
- R1: While reset is held, `mw_cs`, `mw_clk`, `mw_di` and `rsp_valid` are 0, `cmd_ready` is 1 and `busy` is 0.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are both high. From the next cycle on, `cmd_ready` is 0, `busy` is 1 and `mw_cs` is 1. While `cmd_ready` is 1, `mw_cs` is 0.
- R3: Frame bits go out on `mw_di`, most significant first, in this order: a start bit of 1, two opcode bits, a 9-bit address field, then for write and write-all the 8 data bits. The opcode bits are 10 for read, 01 for write, 11 for erase and 00 for the others. For read, write and erase the address field is a 0 followed by address bits 7..0. For the 00-opcode commands its top two bits select the command (10 erase-all, 01 write-all, 11 enable, 00 disable) and the remaining seven bits are 0. The `cmd_op` codes are: 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 enable, 6 disable, and 7 is sent as disable.
- R4: `mw_clk` rises only while `mw_cs` is high. A frame has 12 rising clock edges for erase, erase-all, enable and disable, and 20 for read, write and write-all.
- R5: Each high phase of `mw_clk` lasts exactly CLK_DIV system clocks, and `mw_di` does not change while `mw_clk` is high.
- R6: For a read, the bit sampled before the 13th rising edge (the dummy zero) is discarded. `rsp_data` is made from the bits sampled one system clock before rising edges 14 to 20, followed by one more sample one clock-low phase after edge 20, and holds the addressed byte.
- R7: Every rise of `mw_cs` follows at least CSL_GAP consecutive system clocks with `mw_cs` low.
- R8: After a program frame, the controller raises `mw_cs` again with `mw_clk` and `mw_di` low. It samples `mw_do` once every 2*CLK_DIV system clocks and signals completion only after a sample of 1.
- R9: If POLL_MAX samples in a row read 0, the controller ends the command with `rsp_valid` and `rsp_err` both 1. `rsp_err` is never 1 without `rsp_valid`.
- R10: Each accepted command produces exactly one `rsp_valid` pulse, one cycle long. The pulse is issued as the final chip-select fall of the command.
- R11: The enable and disable commands are sent unchanged. A write issued after a disable, with no enable in between, leaves the stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_op | input | 3 | Operation code (see R3) |
| cmd_addr | input | 8 | Byte address |
| cmd_wdata | input | 8 | Write / write-all value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Read byte, valid with rsp_valid |
| rsp_err | output | 1 | Poll timeout, valid with rsp_valid |
| busy | output | 1 | A command is in progress |
| mw_cs | output | 1 | Serial chip select |
| mw_clk | output | 1 | Serial clock |
| mw_di | output | 1 | Serial data to the device |
| mw_do | input | 1 | Serial data / ready status from the device |

## Verification
Some rules are checked by the assertions on every cycle: the serial clock rises only under chip select, data-in holds still while the clock is high, the chip-select-low gap holds before every rise, the idle state keeps chip select low, and the completion pulse and error flag have the correct shape. Other behaviour can only be shown by the bench's scenarios, driven against a device model it contains. This covers the exact bit content and length of each frame, the discarded dummy bit and the assembled read byte, completion waiting until the device is really ready, timeout under a stuck busy device, and writes that have no effect after a disable.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int HDR_LEN   = 3 + ADDR_W + 1;      // start + opcode + address field
  localparam int FRAME_W   = HDR_LEN + DATA_W;
  localparam int SLOT_W    = $clog2(FRAME_W + 2);

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_ERAL  = 3'd3,
    OP_WRAL  = 3'd4,
    OP_WEN   = 3'd5,
    OP_WDIS  = 3'd6,
    OP_RSVD  = 3'd7
  } uw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_GAP,
    ST_POLL
  } uw_state_e;

  // Full frame, left aligned: start, opcode, address field, data.
  function automatic logic [FRAME_W-1:0] uw_frame(uw_op_e op,
                                                  logic [ADDR_W-1:0] addr,
                                                  logic [DATA_W-1:0] data);
    logic [1:0]      oc;
    logic [ADDR_W:0] af;
    logic [DATA_W-1:0] dd;
    oc = 2'b00;
    af = '0;
    dd = '0;
    case (op)
      OP_READ:  begin oc = 2'b10; af = {1'b0, addr}; end
      OP_WRITE: begin oc = 2'b01; af = {1'b0, addr}; dd = data; end
      OP_ERASE: begin oc = 2'b11; af = {1'b0, addr}; end
      OP_ERAL:  af = {2'b10, {(ADDR_W-1){1'b0}}};
      OP_WRAL:  begin af = {2'b01, {(ADDR_W-1){1'b0}}}; dd = data; end
      OP_WEN:   af = {2'b11, {(ADDR_W-1){1'b0}}};
      default:  af = '0;
    endcase
    return {1'b1, oc, af, dd};
  endfunction

  function automatic logic uw_is_long(uw_op_e op);
    return (op == OP_READ) || (op == OP_WRITE) || (op == OP_WRAL);
  endfunction

  function automatic logic uw_is_prog(uw_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_ERAL) || (op == OP_WRAL);
  endfunction

endpackage

// File: rtl/uwire_div.sv
module uwire_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uwire_shift.sv
module uwire_shift #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  assign msb = sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (load)   sr <= load_val;
    else if (shift)  sr <= {sr[W-2:0], 1'b0};
  end
endmodule

// File: rtl/uwire_cap.sv
module uwire_cap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (shift)  q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/uwire_host.sv
module uwire_host
  import uwire_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int CSL_GAP  = 63,
  parameter int POLL_MAX = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              busy,
  output logic              mw_cs,
  output logic              mw_clk,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int GW = $clog2(CSL_GAP + 1) + 1;
  localparam int PW = $clog2(POLL_MAX + 1) + 1;
  localparam logic [GW-1:0]     GAP_LAST   = GW'(CSL_GAP - 1);
  localparam logic [PW-1:0]     POLL_LAST  = PW'(POLL_MAX - 1);
  localparam logic [SLOT_W-1:0] DUMMY_SLOT = SLOT_W'(HDR_LEN);
  localparam logic [SLOT_W-1:0] SHORT_N    = SLOT_W'(HDR_LEN);
  localparam logic [SLOT_W-1:0] LONG_N     = SLOT_W'(FRAME_W);

  uw_state_e          st;
  logic               cs_q, hi, is_rd, poll_pend, done_q, err_q;
  logic [SLOT_W-1:0]  slot, len_q;
  logic [GW-1:0]      gap_cnt;
  logic [PW-1:0]      polls;
  logic [DATA_W-1:0]  rdata_q, cap_q;
  logic               tick, accept, di_shift, cap_shift;
  uw_op_e             op_in;

  assign op_in     = uw_op_e'(cmd_op);
  assign cmd_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign di_shift  = (st == ST_FRAME) && tick && hi;
  assign cap_shift = (st == ST_FRAME) && tick && !hi && is_rd &&
                     (slot > DUMMY_SLOT) && (slot < len_q);

  assign mw_cs     = cs_q;
  assign mw_clk    = hi && (st == ST_FRAME);
  assign rsp_valid = done_q;
  assign rsp_err   = err_q;
  assign rsp_data  = rdata_q;

  uwire_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n),
    .run((st == ST_FRAME) || (st == ST_POLL)),
    .tick(tick)
  );

  uwire_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_val(uw_frame(op_in, cmd_addr, cmd_wdata)),
    .shift(di_shift), .msb(mw_di)
  );

  uwire_cap #(.W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .shift(cap_shift), .din(mw_do), .q(cap_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cs_q      <= 1'b0;
      hi        <= 1'b0;
      is_rd     <= 1'b0;
      poll_pend <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      slot      <= '0;
      len_q     <= '0;
      gap_cnt   <= '0;
      polls     <= '0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st        <= ST_FRAME;
            cs_q      <= 1'b1;
            hi        <= 1'b0;
            slot      <= '0;
            is_rd     <= (op_in == OP_READ);
            poll_pend <= uw_is_prog(op_in);
            len_q     <= uw_is_long(op_in) ? LONG_N : SHORT_N;
          end
        end
        ST_FRAME: begin
          if (tick) begin
            if (!hi) begin
              if (is_rd && (slot == len_q)) begin
                // tail phase: last data bit sampled, no further rising edge
                rdata_q <= {cap_q[DATA_W-2:0], mw_do};
                done_q  <= 1'b1;
                st      <= ST_GAP;
                cs_q    <= 1'b0;
                gap_cnt <= '0;
              end else begin
                hi <= 1'b1;
              end
            end else begin
              hi <= 1'b0;
              if (!is_rd && (slot == len_q - 1'b1)) begin
                st      <= ST_GAP;
                cs_q    <= 1'b0;
                gap_cnt <= '0;
                if (!poll_pend) done_q <= 1'b1;
              end else begin
                slot <= slot + 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_LAST) begin
            if (poll_pend) begin
              st    <= ST_POLL;
              cs_q  <= 1'b1;
              hi    <= 1'b0;
              polls <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_POLL: begin
          if (tick) begin
            if (!hi) begin
              hi <= 1'b1;
            end else begin
              hi <= 1'b0;
              if (mw_do || (polls == POLL_LAST)) begin
                done_q    <= 1'b1;
                err_q     <= !mw_do;
                poll_pend <= 1'b0;
                st        <= ST_GAP;
                cs_q      <= 1'b0;
                gap_cnt   <= '0;
              end else begin
                polls <= polls + 1'b1;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwire_host_chk.sv
module uwire_host_chk #(
  parameter int CSL_GAP = 63
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic mw_cs,
  input logic mw_clk,
  input logic mw_di
);
  localparam int LW = $clog2(CSL_GAP + 1) + 2;
  localparam logic [LW-1:0] LSAT = LW'(CSL_GAP);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= LSAT;
    else if (mw_cs)          low_cnt <= '0;
    else if (low_cnt < LSAT) low_cnt <= low_cnt + 1'b1;
  end

  // R2
  idle_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mw_cs);

  // R2
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && mw_cs));

  // R4
  clk_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_clk |-> mw_cs);

  // R5
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_clk && $past(mw_clk)) |-> $stable(mw_di));

  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_cs) |-> (low_cnt >= LSAT));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R10
  done_at_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $fell(mw_cs));
endmodule

bind uwire_host uwire_host_chk #(.CSL_GAP(CSL_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .mw_cs(mw_cs),
  .mw_clk(mw_clk), .mw_di(mw_di)
);

// File: tb/uwire_host_bench.sv
module uwire_host_bench;
  localparam int DIV  = 2;
  localparam int GAP  = 63;
  localparam int PMAX = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic       cmd_ready, rsp_valid, rsp_err, busy, mw_cs, mw_clk, mw_di;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_addr = 8'd0, cmd_wdata = 8'd0, rsp_data;
  logic       dev_do;

  uwire_host #(.CLK_DIV(DIV), .CSL_GAP(GAP), .POLL_MAX(PMAX)) u_uwire_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .busy(busy),
    .mw_cs(mw_cs), .mw_clk(mw_clk), .mw_di(mw_di), .mw_do(dev_do)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0]  mem [256];
  logic [19:0] sh, log_sh;
  int  nb, log_n, nframes, busy_cnt, busy_len, lowc, hil, gap_bad, hp_bad;
  bit  started, rd_act, rd_b, dev_en, cs_p, clk_p;
  logic [7:0] rd_a;

  task automatic dev_exec();
    logic [11:0] f;
    logic [7:0]  d;
    if (nb == 12) begin f = sh[11:0]; d = 8'h00; end
    else if (nb == 20) begin f = sh[19:8]; d = sh[7:0]; end
    else return;
    case (f[10:9])
      2'b00: case (f[8:7])
        2'b11: dev_en = 1;
        2'b00: dev_en = 0;
        2'b10: if (dev_en && nb == 12) begin
                 for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
                 busy_cnt = busy_len;
               end
        default: if (dev_en && nb == 20) begin
                 for (int i = 0; i < 256; i++) mem[i] = d;
                 busy_cnt = busy_len;
               end
      endcase
      2'b01: if (dev_en && nb == 20) begin mem[f[7:0]] = d; busy_cnt = busy_len; end
      2'b11: if (dev_en && nb == 12) begin mem[f[7:0]] = 8'hFF; busy_cnt = busy_len; end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
      nb = 0; started = 0; rd_act = 0; rd_b = 0; dev_en = 0;
      busy_cnt = 0; lowc = GAP; hil = 0; cs_p = 0; clk_p = 0;
      dev_do <= 1'b1;
    end else begin
      if (busy_cnt > 0) busy_cnt--;
      if (mw_cs && !cs_p) begin
        if (lowc < GAP) gap_bad++;
        nb = 0; started = 0; rd_act = 0;
      end
      if (!mw_cs) lowc++; else lowc = 0;
      if (mw_clk && !clk_p) begin
        hil = 1;
        if (mw_cs) begin
          if (!started && mw_di) started = 1;
          if (started) begin
            sh = {sh[18:0], mw_di};
            nb++;
            if (nb == 12 && sh[10:9] == 2'b10) begin
              rd_act = 1; rd_a = sh[7:0]; rd_b = 0;
            end else if (rd_act && nb > 12 && nb <= 20) begin
              rd_b = mem[rd_a][20-nb];
            end
          end
        end
      end else if (mw_clk) hil++;
      if (!mw_clk && clk_p && hil != DIV) hp_bad++;
      if (!mw_cs && cs_p && started) begin
        log_n = nb; log_sh = sh; nframes++;
        dev_exec();
        started = 0; rd_act = 0;
      end
      cs_p = mw_cs; clk_p = mw_clk;
      dev_do <= !mw_cs ? 1'b1 : (rd_act ? rd_b : (busy_cnt > 0 ? 1'b0 : 1'b1));
    end
  end

  // ---------------- reference ----------------
  logic [7:0] ref_mem [256];
  bit ref_en = 0;

  function automatic logic [19:0] exp_frame(int op, logic [7:0] a, logic [7:0] d);
    case (op)
      0: return {3'b110, 1'b0, a, 8'h00};
      1: return {3'b101, 1'b0, a, d};
      2: return {3'b111, 1'b0, a, 8'h00};
      3: return {3'b100, 9'h100, 8'h00};
      4: return {3'b100, 9'h080, d};
      5: return {3'b100, 9'h180, 8'h00};
      default: return {3'b100, 9'h000, 8'h00};
    endcase
  endfunction

  function automatic int exp_len(int op);
    return (op == 0 || op == 1 || op == 4) ? 20 : 12;
  endfunction

  function automatic bit is_prog(int op);
    return op >= 1 && op <= 4;
  endfunction

  task automatic ref_update(int op, logic [7:0] a, logic [7:0] d);
    case (op)
      1: if (ref_en) ref_mem[a] = d;
      2: if (ref_en) ref_mem[a] = 8'hFF;
      3: if (ref_en) for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
      4: if (ref_en) for (int i = 0; i < 256; i++) ref_mem[i] = d;
      5: ref_en = 1;
      6, 7: ref_en = 0;
      default: ;
    endcase
  endtask

  logic [7:0] last_rd;
  bit         last_err;

  task automatic run(int op, logic [7:0] a, logic [7:0] d);
    int n0, cnt;
    logic [19:0] got;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    n0 = nframes;
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready && busy && mw_cs, "R2", "not busy after accept", int'(cmd_ready), 0);
    cnt = 0;
    while (!rsp_valid && cnt < 20000) begin @(negedge clk); cnt++; end
    chk(rsp_valid, "R10", "no completion pulse", int'(rsp_valid), 1);
    last_rd = rsp_data; last_err = rsp_err;
    @(negedge clk);
    chk(!rsp_valid, "R10", "pulse longer than one cycle", int'(rsp_valid), 0);
    while (!cmd_ready) @(negedge clk);
    chk(nframes == n0 + 1, "R4", "frame count", nframes - n0, 1);
    chk(log_n == exp_len(op), "R4", "rising edges in frame", log_n, exp_len(op));
    got = (log_n == 12) ? {log_sh[11:0], 8'h00} : log_sh;
    chk(got == exp_frame(op, a, d), "R3", "frame bits", int'(got), int'(exp_frame(op, a, d)));
    if (is_prog(op) && !last_err)
      chk(busy_cnt == 0, "R8", "done while device busy", busy_cnt, 0);
    ref_update(op, a, d);
    if (op == 0)
      chk(last_rd == ref_mem[a], "R6", "read data", int'(last_rd), int'(ref_mem[a]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'h3C;
    nframes = 0; gap_bad = 0; hp_bad = 0; busy_len = 80;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!mw_cs && !mw_clk && !mw_di, "R1", "serial pins in reset", int'({mw_cs, mw_clk, mw_di}), 0);
    chk(cmd_ready && !busy && !rsp_valid, "R1", "handshake in reset",
        int'({cmd_ready, busy, rsp_valid}), 4);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R11: write while disabled has no effect
    run(1, 8'h05, 8'hA5);
    chk(!last_err, "R9", "spurious error", int'(last_err), 0);
    run(0, 8'h05, 8'h00);
    run(5, 8'h00, 8'h00);
    run(1, 8'h05, 8'hA5);
    run(0, 8'h05, 8'h00);
    run(1, 8'hFF, 8'h80);
    run(1, 8'h00, 8'h01);
    run(0, 8'hFF, 8'h00);
    run(0, 8'h00, 8'h00);
    run(2, 8'h10, 8'h00);
    run(0, 8'h10, 8'h00);
    // R11: reserved code behaves as disable
    run(7, 8'h00, 8'h00);
    run(1, 8'h20, 8'h77);
    run(0, 8'h20, 8'h00);
    chk(last_rd != 8'h77, "R11", "write after disable took effect", int'(last_rd), int'(ref_mem[8'h20]));
    run(5, 8'h00, 8'h00);
    run(3, 8'h00, 8'h00);
    run(0, 8'h42, 8'h00);
    run(4, 8'h00, 8'h5A);
    run(0, 8'hC3, 8'h00);

    // constrained random mix
    for (int k = 0; k < 30; k++) begin
      int r, op;
      r = int'($urandom % 10);
      op = (r < 4) ? 0 : (r < 6) ? 1 : (r == 6) ? 2 : (r == 8) ? 6 : 5;
      busy_len = 60 + int'($urandom % 140);
      run(op, 8'($urandom), 8'($urandom));
    end

    // R9 timeout with a stuck-busy device
    run(5, 8'h00, 8'h00);
    busy_len = 3000;
    run(1, 8'h33, 8'h9C);
    chk(last_err, "R9", "timeout not flagged", int'(last_err), 1);
    chk(busy_cnt > 0, "R9", "device should still be busy", busy_cnt, 1);
    while (busy_cnt > 0) @(negedge clk);
    busy_len = 80;
    run(0, 8'h33, 8'h00);

    chk(gap_bad == 0, "R7", "short chip-select gaps", gap_bad, 0);
    chk(hp_bad == 0, "R5", "wrong clock high phase", hp_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule